// File: doc/BRIEF.md
# Operating Mode Control Sequencer

This block holds the mode-control state of a processor that boots in flat real addressing and steps up to a 64-bit long mode. It keeps five bits: protection on, paging on, physical address extension on, long mode armed, and long mode active. Software changes these bits by strobing writes into three control words: a primary control word, a secondary control word and an extended feature word. A code-segment load also supplies the long-mode flag of the loaded descriptor. From this state the block reports the current operating mode as real, protected, compatibility or 64-bit.

The hardware enforces the order of the enable steps. A write that would leave the state in an illegal combination raises a one-cycle general-protection fault pulse, and every write presented in that cycle is discarded. Long-mode-active is never written directly. It follows paging and long-mode-armed. The split between compatibility mode and 64-bit mode comes from the descriptor flag of code-segment loads made while long mode stays active.

All inputs are plain control strobes sampled on the rising clock edge, so there is no back-pressure. Every output is registered and reflects the writes of the previous cycle.

Top module: `mc_mode_seq`

## Requirements
- R1: After reset every state bit reads 0, the mode reads 2'b00 and the fault flag is 0.
- R2: A legal primary write loads protection-on from data bit 0 and paging-on from data bit 31; the outputs show the new values one cycle after the write cycle.
- R3: A legal secondary write loads address-extension-on from data bit 5.
- R4: A legal feature write loads long-mode-armed from data bit 8.
- R5: A cycle whose writes would leave long-mode-armed at 1 with address extension at 0 faults. This covers setting the armed bit while extension is off and clearing extension while armed. All writes of that cycle are discarded, and so is any code-segment load.
- R6: The fault flag is high for exactly the one cycle after a faulting write cycle and is never high after a cycle without a write strobe.
- R7: Long-mode-active rises in the same update that sets paging-on while long-mode-armed is 1. Paging set with the armed bit at 0 leaves it at 0.
- R8: The mode output is 2'b00 (real) while protection-on is 0, and 2'b01 (protected) when protection-on is 1 and long mode is not active.
- R9: On entry to long-mode-active the mode is 2'b10 (compatibility). A code-segment load with the long flag at 1, made while long mode was already active, gives 2'b11 (64-bit); one with the flag at 0 gives 2'b10. A load in the cycle of entry is ignored.
- R10: A legal write that clears paging-on also clears long-mode-active and returns the mode to 2'b01. Re-entering long mode afterwards starts in compatibility mode again.
- R11: When several writes fall in the same cycle, the legality checks use the combined state the whole cycle would leave, not the state before it.
- R12: A cycle that would leave paging-on at 1 with protection-on at 0 faults. So does a cycle that changes long-mode-armed while paging is on before or after the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prim_wr | input | 1 | Primary control word write strobe |
| prim_wdata | input | CTL_W | Primary write data (bit 0 protection, bit 31 paging) |
| sec_wr | input | 1 | Secondary control word write strobe |
| sec_wdata | input | CTL_W | Secondary write data (bit 5 address extension) |
| feat_wr | input | 1 | Extended feature word write strobe |
| feat_wdata | input | FEAT_W | Feature write data (bit 8 long-mode armed) |
| cs_load | input | 1 | Code-segment load strobe |
| cs_desc_long | input | 1 | Long flag of the loaded code descriptor |
| mode_o | output | 2 | 00 real, 01 protected, 10 compatibility, 11 64-bit |
| prot_en_o | output | 1 | Protection-on bit |
| page_en_o | output | 1 | Paging-on bit |
| addr_ext_o | output | 1 | Address-extension-on bit |
| long_en_o | output | 1 | Long-mode-armed bit |
| long_act_o | output | 1 | Long-mode-active status |
| gp_fault_o | output | 1 | General-protection fault pulse |

## Verification
Every result, including the fault pulse, the state bits and the mode, appears at the first rising edge after the cycle in which the strobes are driven. No result is due later than that. The driver sets the strobes on a falling edge and queues the complete expected output word for that step. The monitor pops it 2 ns after the next rising edge and compares all outputs at once. The same-cycle write combinations, the ignored load in the entry cycle and the frozen state after a fault are therefore all checked on the exact cycle they become visible.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_REAL   = 2'b00,
    MODE_PROT   = 2'b01,
    MODE_COMPAT = 2'b10,
    MODE_LONG64 = 2'b11
  } mode_e;

  typedef struct packed {
    logic pe;  // protection on
    logic pg;  // paging on
    logic ae;  // address extension on
    logic le;  // long mode armed
  } ctl_bits_t;

endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_pkg::*;
(
  input  ctl_bits_t cur,
  input  logic      prim_wr,
  input  logic      prim_pe,
  input  logic      prim_pg,
  input  logic      sec_wr,
  input  logic      sec_ae,
  input  logic      feat_wr,
  input  logic      feat_le,
  output ctl_bits_t nxt,
  output logic      fault
);

  logic f_prot, f_ext, f_lock;

  // Merge every strobe of the cycle first; the checks judge the result.
  always_comb begin
    nxt    = cur;
    if (prim_wr) begin
      nxt.pe = prim_pe;
      nxt.pg = prim_pg;
    end
    if (sec_wr)  nxt.ae = sec_ae;
    if (feat_wr) nxt.le = feat_le;
  end

  always_comb begin
    f_prot = nxt.pg && !nxt.pe;
    f_ext  = nxt.le && !nxt.ae;
    f_lock = (nxt.le != cur.le) && (cur.pg || nxt.pg);
    fault  = f_prot || f_ext || f_lock;
  end

endmodule

// File: rtl/mc_long_track.sv
module mc_long_track (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic nxt_pg,
  input  logic nxt_le,
  input  logic cs_load,
  input  logic cs_desc_long,
  output logic long_act,
  output logic cs_long
);

  logic act_n;

  always_comb act_n = nxt_pg && nxt_le;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      long_act <= 1'b0;
      cs_long  <= 1'b0;
    end else if (upd) begin
      long_act <= act_n;
      if (!act_n || !long_act) cs_long <= 1'b0;
      else if (cs_load)        cs_long <= cs_desc_long;
    end
  end

  AST_ENTRY_IS_COMPAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_act) |-> !cs_long); // R9

  AST_CS_LONG_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_long |-> long_act); // R10

endmodule

// File: rtl/mc_mode_enc.sv
module mc_mode_enc
  import mc_pkg::*;
(
  input  logic  pe,
  input  logic  long_act,
  input  logic  cs_long,
  output mode_e mode
);

  always_comb begin
    if (!pe)           mode = MODE_REAL;
    else if (!long_act) mode = MODE_PROT;
    else if (cs_long)  mode = MODE_LONG64;
    else               mode = MODE_COMPAT;
  end

endmodule

// File: rtl/mc_mode_seq.sv
module mc_mode_seq
  import mc_pkg::*;
#(
  parameter int CTL_W  = 32,
  parameter int FEAT_W = 32,
  parameter int PE_POS = 0,
  parameter int PG_POS = 31,
  parameter int AE_POS = 5,
  parameter int LE_POS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prim_wr,
  input  logic [CTL_W-1:0]  prim_wdata,
  input  logic              sec_wr,
  input  logic [CTL_W-1:0]  sec_wdata,
  input  logic              feat_wr,
  input  logic [FEAT_W-1:0] feat_wdata,
  input  logic              cs_load,
  input  logic              cs_desc_long,
  output logic [1:0]        mode_o,
  output logic              prot_en_o,
  output logic              page_en_o,
  output logic              addr_ext_o,
  output logic              long_en_o,
  output logic              long_act_o,
  output logic              gp_fault_o
);

  ctl_bits_t cur_q, nxt;
  logic      fault, fault_q;
  logic      long_act, cs_long;
  mode_e     mode;

  mc_next_state u_next (
    .cur     (cur_q),
    .prim_wr (prim_wr),
    .prim_pe (prim_wdata[PE_POS]),
    .prim_pg (prim_wdata[PG_POS]),
    .sec_wr  (sec_wr),
    .sec_ae  (sec_wdata[AE_POS]),
    .feat_wr (feat_wr),
    .feat_le (feat_wdata[LE_POS]),
    .nxt     (nxt),
    .fault   (fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault;
      if (!fault) cur_q <= nxt;
    end
  end

  mc_long_track u_long (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd          (!fault),
    .nxt_pg       (nxt.pg),
    .nxt_le       (nxt.le),
    .cs_load      (cs_load),
    .cs_desc_long (cs_desc_long),
    .long_act     (long_act),
    .cs_long      (cs_long)
  );

  mc_mode_enc u_enc (
    .pe       (cur_q.pe),
    .long_act (long_act),
    .cs_long  (cs_long),
    .mode     (mode)
  );

  assign mode_o     = mode;
  assign prot_en_o  = cur_q.pe;
  assign page_en_o  = cur_q.pg;
  assign addr_ext_o = cur_q.ae;
  assign long_en_o  = cur_q.le;
  assign long_act_o = long_act;
  assign gp_fault_o = fault_q;

  AST_FAULT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault_o |-> $past(prim_wr || sec_wr || feat_wr)); // R6

  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault_o |-> (cur_q == $past(cur_q))); // R5

  AST_LONG_EN_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    long_en_o |-> addr_ext_o); // R5

  AST_PAGE_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    page_en_o |-> prot_en_o); // R12

  AST_ACT_FOLLOWS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    long_act_o == (page_en_o && long_en_o)); // R7

  AST_REAL_WITHOUT_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en_o |-> (mode_o == 2'b00)); // R8

  AST_WIDE_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[1] |-> long_act_o); // R9

endmodule

// File: tb/test_mc_mode_seq.sv
module test_mc_mode_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prim_wr = 1'b0, sec_wr = 1'b0, feat_wr = 1'b0;
  logic [31:0] prim_wdata = '0, sec_wdata = '0, feat_wdata = '0;
  logic        cs_load = 1'b0, cs_desc_long = 1'b0;
  logic [1:0]  mode_o;
  logic        prot_en_o, page_en_o, addr_ext_o, long_en_o, long_act_o, gp_fault_o;

  always #5 clk = ~clk;

  mc_mode_seq i_mc_mode_seq (
    .clk, .rst_n, .prim_wr, .prim_wdata, .sec_wr, .sec_wdata,
    .feat_wr, .feat_wdata, .cs_load, .cs_desc_long,
    .mode_o, .prot_en_o, .page_en_o, .addr_ext_o, .long_en_o,
    .long_act_o, .gp_fault_o
  );

  typedef struct {
    logic [7:0] exp;  // {mode[1:0], pe, pg, ae, le, act, fault}
    string      req;
  } item_t;

  item_t q[$];
  int    n_run = 0, n_fail = 0;
  bit    done = 1'b0;

  task automatic step(input logic pw, input logic [31:0] pd,
                      input logic sw, input logic [31:0] sd,
                      input logic fw, input logic [31:0] fd,
                      input logic cl, input logic cb,
                      input logic [7:0] exp, input string req);
    item_t it;
    @(negedge clk);
    prim_wr = pw; prim_wdata = pd;
    sec_wr  = sw; sec_wdata  = sd;
    feat_wr = fw; feat_wdata = fd;
    cs_load = cl; cs_desc_long = cb;
    it.exp = exp; it.req = req;
    q.push_back(it);
    @(posedge clk);
    #1;
    prim_wr = 1'b0; sec_wr = 1'b0; feat_wr = 1'b0; cs_load = 1'b0;
  endtask

  // monitor: outputs of each step are due at the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = {mode_o, prot_en_o, page_en_o, addr_ext_o, long_en_o,
               long_act_o, gp_fault_o};
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %b expected %b", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 8'b00_000000, "R1 reset state");
    step(1, 32'h1, 0, 0, 0, 0, 0, 0, 8'b01_100000, "R2 protection on");
    step(1, 32'h8000_0000, 0, 0, 0, 0, 0, 0, 8'b01_100001, "R12 paging without protection");
    step(0, 0, 0, 0, 1, 32'h100, 0, 0, 8'b01_100001, "R5 arm long without extension");
    step(0, 0, 0, 0, 0, 0, 0, 0, 8'b01_100000, "R6 fault is one cycle");
    step(0, 0, 1, 32'h20, 0, 0, 0, 0, 8'b01_101000, "R3 extension on");
    step(0, 0, 0, 0, 1, 32'h100, 0, 0, 8'b01_101100, "R4 long armed");
    step(1, 32'h8000_0001, 0, 0, 0, 0, 0, 0, 8'b10_111110, "R7 paging sets active");
    step(0, 0, 0, 0, 0, 0, 1, 1, 8'b11_111110, "R9 long code load");
    step(0, 0, 0, 0, 1, 32'h0, 0, 0, 8'b11_111111, "R12 disarm while paging");
    step(0, 0, 1, 32'h0, 0, 0, 0, 0, 8'b11_111111, "R5 clear extension while armed");
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'b10_111110, "R9 legacy code load");
    step(0, 0, 0, 0, 0, 0, 1, 1, 8'b11_111110, "R9 long code load again");
    step(1, 32'h1, 0, 0, 0, 0, 0, 0, 8'b01_101100, "R10 paging off");
    step(1, 32'h8000_0001, 0, 0, 0, 0, 0, 0, 8'b10_111110, "R10 re-entry is compat");
    step(1, 32'h1, 0, 0, 0, 0, 0, 0, 8'b01_101100, "R10 paging off again");
    step(0, 0, 0, 0, 1, 32'h0, 0, 0, 8'b01_101000, "R4 disarm with paging off");
    step(1, 32'h8000_0001, 0, 0, 0, 0, 0, 0, 8'b01_111000, "R7 paging unarmed");
    step(1, 32'h0, 0, 0, 0, 0, 0, 0, 8'b00_001000, "R8 back to real");
    step(0, 0, 1, 32'h0, 1, 32'h100, 0, 0, 8'b00_001001, "R11 clear ext and arm together");
    step(0, 0, 1, 32'h0, 0, 0, 0, 0, 8'b00_000000, "R3 extension off");
    step(0, 0, 1, 32'h20, 1, 32'h100, 0, 0, 8'b00_001100, "R11 ext and arm together");
    step(1, 32'h8000_0001, 0, 0, 0, 0, 1, 1, 8'b10_111110, "R9 load in entry cycle ignored");
    step(1, 32'h0, 1, 32'h0, 0, 0, 0, 0, 8'b10_111111, "R5 fault discards all writes");
    step(0, 0, 0, 0, 0, 0, 1, 1, 8'b11_111110, "R9 load after entry");
    step(1, 32'h8000_0000, 0, 0, 1, 32'h0, 0, 0, 8'b11_111111, "R12 paging kept without protection");
    step(0, 0, 0, 0, 0, 0, 0, 0, 8'b11_111110, "R6 fault cleared");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule